// File: doc/BRIEF.md
# Dual-Port Mailbox With Interrupt Handshake

This block lets a host bus and an intelligent processor on a local bus exchange short messages. Each side has its own simple register port with a read strobe, a write strobe, an address, write data and registered read data. Both ports run on the same clock. For each direction there is a command word and four 32-bit data words. A side can only read what the opposite side last wrote. A host read at a given address returns the local side's value, and a local read returns the host side's value.

Each command word carries one doorbell flag. To send a message, the host first fills its data words. It then writes the command word with the host-to-local flag (bit 0) set. This raises `loc_irq`. The local processor reads the command word, which drops the flag and the interrupt, and then reads the data. It acknowledges by writing its own command word with the local-to-host flag (bit 1) set. This raises `host_irq` until the host reads its command word.

Top module: `mbox_core`

## Requirements
- R1: Reset (synchronous, active high) clears both flags and both interrupt outputs. After reset, every address read from either port returns zero.
- R2: Address 0 is the command word. A host read of address 0 returns the word the local side last wrote there. A local read of address 0 returns the word the host last wrote there.
- R3: Addresses 1 to 4 are data words 0 to 3 of each direction. A word written by one side at address k is returned to the other side reading address k. Writes by the host never appear on the host's own read data, and the same holds for the local side.
- R4: A host write to address 0 with bit 0 set raises `loc_irq` on the next cycle. A local read of address 0 then returns bit 0 as 1.
- R5: A local read of address 0 clears the host-to-local flag. `loc_irq` is low from the cycle after the read strobe.
- R6: A local write to address 0 with bit 1 set raises `host_irq` on the next cycle. A host read of address 0 then returns bit 1 as 1.
- R7: A host read of address 0 clears the local-to-host flag. `host_irq` is low from the cycle after the read strobe.
- R8: A command write with its flag bit at 0 leaves that flag and its interrupt unchanged, whether the flag was set or clear. The flag bit position is not stored as a message bit.
- R9: If a flag is set by a write and cleared by a read in the same cycle, the flag ends up set. That read returns the flag value from before the cycle.
- R10: Read data is registered. It changes only on the cycle after a read strobe and otherwise holds. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| host_irq | output | 1 | Interrupt to host, local-to-host flag |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| loc_addr | input | 3 | Local register address |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local read data, registered |
| loc_irq | output | 1 | Interrupt to local side, host-to-local flag |

## Verification
A complete message round trip is run in both directions: data fill, doorbell, clearing read and acknowledge. Each data word and command word uses distinct upper bits, so any swap between the two images or any address aliasing shows up as a wrong word. Command writes with the flag bit at zero are made both with the flag clear and with it set, which tells a set-only flag apart from a plainly stored bit. Same-cycle set and clear on each flag, and a same-cycle write and read of one data address, separate the set-wins rule and the read-before-write timing from the alternatives. Out-of-range reads and a mid-run reset complete the run.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int MBX_DATA_W   = 32;
    localparam int MBX_NUM_DATA = 4;
    localparam int MBX_H2L_BIT  = 0;
    localparam int MBX_L2H_BIT  = 1;

    typedef enum logic [1:0] {
        RSEL_CMD  = 2'd0,
        RSEL_DATA = 2'd1,
        RSEL_NONE = 2'd2
    } rsel_e;

    typedef struct packed {
        logic set;
        logic clr;
    } flag_evt_t;

    function automatic int addr_bits(input int n);
        int b;
        b = $clog2(n + 1);
        return (b < 1) ? 1 : b;
    endfunction

    function automatic rsel_e classify(input int addr, input int n);
        if (addr == 0)
            return RSEL_CMD;
        else if (addr <= n)
            return RSEL_DATA;
        else
            return RSEL_NONE;
    endfunction

    function automatic logic next_flag(input logic cur, input flag_evt_t e);
        return e.set | (cur & ~e.clr);
    endfunction

endpackage

// File: rtl/mbox_dir_bank.sv
module mbox_dir_bank
    import mbox_pkg::*;
#(
    parameter int DATA_W   = MBX_DATA_W,
    parameter int NUM_DATA = MBX_NUM_DATA,
    parameter int ADDR_W   = addr_bits(MBX_NUM_DATA),
    parameter int FLAG_BIT = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          cmd_image,
    output logic [NUM_DATA*DATA_W-1:0] data_flat,
    output logic                       flag
);

    localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;

    rsel_e             wr_sel;
    rsel_e             rd_sel;
    flag_evt_t         evt;
    logic [DATA_W-1:0] cmd_body;

    always_comb begin
        wr_sel  = classify(int'(wr_addr), NUM_DATA);
        rd_sel  = classify(int'(rd_addr), NUM_DATA);
        evt.set = wr_en && (wr_sel == RSEL_CMD) && wr_data[FLAG_BIT];
        evt.clr = rd_en && (rd_sel == RSEL_CMD);
    end

    // message bits of the command word; the doorbell position is never stored
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_body <= '0;
            flag     <= 1'b0;
        end else begin
            flag <= next_flag(flag, evt);
            if (wr_en && (wr_sel == RSEL_CMD))
                cmd_body <= wr_data & ~FLAG_MASK;
        end
    end

    assign cmd_image = cmd_body | (flag ? FLAG_MASK : '0);

    for (genvar g = 0; g < NUM_DATA; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (wr_en && (wr_sel == RSEL_DATA) && (wr_addr == ADDR_W'(g + 1)))
                word_q <= wr_data;
        end
        assign data_flat[g*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/mbox_read_port.sv
module mbox_read_port
    import mbox_pkg::*;
#(
    parameter int DATA_W   = MBX_DATA_W,
    parameter int NUM_DATA = MBX_NUM_DATA,
    parameter int ADDR_W   = addr_bits(MBX_NUM_DATA)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [DATA_W-1:0]          cmd_image,
    input  logic [NUM_DATA*DATA_W-1:0] data_flat,
    output logic [DATA_W-1:0]          rdata
);

    rsel_e             sel;
    logic [DATA_W-1:0] mux;

    always_comb begin
        sel = classify(int'(rd_addr), NUM_DATA);
        mux = '0;
        unique case (sel)
            RSEL_CMD:  mux = cmd_image;
            RSEL_DATA: begin
                for (int i = 0; i < NUM_DATA; i++)
                    if (rd_addr == ADDR_W'(i + 1))
                        mux = data_flat[i*DATA_W +: DATA_W];
            end
            default:   mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= mux;
    end

endmodule

// File: rtl/mbox_core.sv
module mbox_core
    import mbox_pkg::*;
#(
    parameter int DATA_W   = MBX_DATA_W,
    parameter int NUM_DATA = MBX_NUM_DATA,
    parameter int ADDR_W   = addr_bits(MBX_NUM_DATA),
    parameter int H2L_BIT  = MBX_H2L_BIT,
    parameter int L2H_BIT  = MBX_L2H_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_irq,
    input  logic              loc_wr,
    input  logic              loc_rd,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] loc_rdata,
    output logic              loc_irq
);

    localparam int BANK_W = NUM_DATA * DATA_W;

    logic [DATA_W-1:0] h2l_cmd, l2h_cmd;
    logic [BANK_W-1:0] h2l_data, l2h_data;

    // written by host, read and acknowledged by the local side
    mbox_dir_bank #(
        .DATA_W(DATA_W), .NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W), .FLAG_BIT(H2L_BIT)
    ) u_h2l (
        .clk(clk), .rst(rst),
        .wr_en(host_wr), .wr_addr(host_addr), .wr_data(host_wdata),
        .rd_en(loc_rd), .rd_addr(loc_addr),
        .cmd_image(h2l_cmd), .data_flat(h2l_data), .flag(loc_irq)
    );

    // written by the local side, read and acknowledged by host
    mbox_dir_bank #(
        .DATA_W(DATA_W), .NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W), .FLAG_BIT(L2H_BIT)
    ) u_l2h (
        .clk(clk), .rst(rst),
        .wr_en(loc_wr), .wr_addr(loc_addr), .wr_data(loc_wdata),
        .rd_en(host_rd), .rd_addr(host_addr),
        .cmd_image(l2h_cmd), .data_flat(l2h_data), .flag(host_irq)
    );

    mbox_read_port #(
        .DATA_W(DATA_W), .NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W)
    ) u_host_rp (
        .clk(clk), .rst(rst), .rd_en(host_rd), .rd_addr(host_addr),
        .cmd_image(l2h_cmd), .data_flat(l2h_data), .rdata(host_rdata)
    );

    mbox_read_port #(
        .DATA_W(DATA_W), .NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W)
    ) u_loc_rp (
        .clk(clk), .rst(rst), .rd_en(loc_rd), .rd_addr(loc_addr),
        .cmd_image(h2l_cmd), .data_flat(h2l_data), .rdata(loc_rdata)
    );

endmodule

// File: rtl/mbox_core_chk.sv
module mbox_core_chk
    import mbox_pkg::*;
#(
    parameter int DATA_W = MBX_DATA_W,
    parameter int ADDR_W = addr_bits(MBX_NUM_DATA)
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_flag_in,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_irq,
    input logic              loc_wr,
    input logic              loc_rd,
    input logic [ADDR_W-1:0] loc_addr,
    input logic              loc_flag_in,
    input logic [DATA_W-1:0] loc_rdata,
    input logic              loc_irq
);

    logic h2l_set, h2l_clr, l2h_set, l2h_clr;
    assign h2l_set = host_wr && (host_addr == '0) && host_flag_in;
    assign h2l_clr = loc_rd  && (loc_addr  == '0);
    assign l2h_set = loc_wr  && (loc_addr  == '0) && loc_flag_in;
    assign l2h_clr = host_rd && (host_addr == '0);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!loc_irq && !host_irq && host_rdata == '0 && loc_rdata == '0));

    a_r4_set_raises_loc_irq: assert property (@(posedge clk) disable iff (rst)
        h2l_set |=> loc_irq);

    a_r5_read_drops_loc_irq: assert property (@(posedge clk) disable iff (rst)
        (h2l_clr && !h2l_set) |=> !loc_irq);

    a_r6_set_raises_host_irq: assert property (@(posedge clk) disable iff (rst)
        l2h_set |=> host_irq);

    a_r7_read_drops_host_irq: assert property (@(posedge clk) disable iff (rst)
        (l2h_clr && !l2h_set) |=> !host_irq);

    a_r8_loc_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (!h2l_set && !h2l_clr) |=> $stable(loc_irq));

    a_r8_host_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (!l2h_set && !l2h_clr) |=> $stable(host_irq));

    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (h2l_set && h2l_clr) || (l2h_set && l2h_clr) |=>
            ((loc_irq || !$past(h2l_set)) && (host_irq || !$past(l2h_set))));

    a_r10_host_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata));

    a_r10_loc_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !loc_rd |=> $stable(loc_rdata));

endmodule

bind mbox_core mbox_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_flag_in(host_wdata[H2L_BIT]), .host_rdata(host_rdata), .host_irq(host_irq),
    .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_addr(loc_addr),
    .loc_flag_in(loc_wdata[L2H_BIT]), .loc_rdata(loc_rdata), .loc_irq(loc_irq)
);

// File: tb/mbox_core_test.sv
module mbox_core_test;

    localparam time CLK_P = 20ns;

    typedef struct packed {
        logic [3:0]  req;
        logic        hw;
        logic        hr;
        logic [2:0]  ha;
        logic [31:0] hd;
        logic        lw;
        logic        lr;
        logic [2:0]  la;
        logic [31:0] ld;
        logic [31:0] eh;
        logic [31:0] el;
        logic        eli;
        logic        ehi;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        // R1 idle after reset
        '{4'd1, 1'b0,1'b0,3'd0,32'h0,          1'b0,1'b0,3'd0,32'h0,          32'h0,         32'h0,         1'b0,1'b0},
        // R3 host fills data words 0 and 3
        '{4'd3, 1'b1,1'b0,3'd1,32'h1111_0001,  1'b0,1'b0,3'd0,32'h0,          32'h0,         32'h0,         1'b0,1'b0},
        '{4'd3, 1'b1,1'b0,3'd4,32'h4444_0004,  1'b0,1'b0,3'd0,32'h0,          32'h0,         32'h0,         1'b0,1'b0},
        // R3 local reads them back
        '{4'd3, 1'b0,1'b0,3'd0,32'h0,          1'b0,1'b1,3'd1,32'h0,          32'h0,         32'h1111_0001, 1'b0,1'b0},
        '{4'd3, 1'b0,1'b0,3'd0,32'h0,          1'b0,1'b1,3'd4,32'h0,          32'h0,         32'h4444_0004, 1'b0,1'b0},
        // R3 host does not see its own write
        '{4'd3, 1'b0,1'b1,3'd1,32'h0,          1'b0,1'b0,3'd0,32'h0,          32'h0,         32'h4444_0004, 1'b0,1'b0},
        // R4 host doorbell
        '{4'd4, 1'b1,1'b0,3'd0,32'hABCD_0001,  1'b0,1'b0,3'd0,32'h0,          32'h0,         32'h4444_0004, 1'b1,1'b0},
        // R5 local read sees flag and clears it; R2 image
        '{4'd5, 1'b0,1'b0,3'd0,32'h0,          1'b0,1'b1,3'd0,32'h0,          32'h0,         32'hABCD_0001, 1'b0,1'b0},
        '{4'd2, 1'b0,1'b0,3'd0,32'h0,          1'b0,1'b1,3'd0,32'h0,          32'h0,         32'hABCD_0000, 1'b0,1'b0},
        // R3 local data word 1
        '{4'd3, 1'b0,1'b0,3'd0,32'h0,          1'b1,1'b0,3'd2,32'h2222_0002,  32'h0,         32'hABCD_0000, 1'b0,1'b0},
        // R6 local doorbell
        '{4'd6, 1'b0,1'b0,3'd0,32'h0,          1'b1,1'b0,3'd0,32'h5A5A_0002,  32'h0,         32'hABCD_0000, 1'b0,1'b1},
        // R7 data read does not clear
        '{4'd7, 1'b0,1'b1,3'd2,32'h0,          1'b0,1'b0,3'd0,32'h0,          32'h2222_0002, 32'hABCD_0000, 1'b0,1'b1},
        // R7 host command read clears; R6 bit 1 seen
        '{4'd7, 1'b0,1'b1,3'd0,32'h0,          1'b0,1'b0,3'd0,32'h0,          32'h5A5A_0002, 32'hABCD_0000, 1'b0,1'b0},
        '{4'd2, 1'b0,1'b1,3'd0,32'h0,          1'b0,1'b0,3'd0,32'h0,          32'h5A5A_0000, 32'hABCD_0000, 1'b0,1'b0},
        // R8 zero flag bit while clear
        '{4'd8, 1'b1,1'b0,3'd0,32'h0000_1230,  1'b0,1'b0,3'd0,32'h0,          32'h5A5A_0000, 32'hABCD_0000, 1'b0,1'b0},
        '{4'd4, 1'b1,1'b0,3'd0,32'h0000_0001,  1'b0,1'b0,3'd0,32'h0,          32'h5A5A_0000, 32'hABCD_0000, 1'b1,1'b0},
        // R8 zero flag bit while set
        '{4'd8, 1'b1,1'b0,3'd0,32'h0000_7770,  1'b0,1'b0,3'd0,32'h0,          32'h5A5A_0000, 32'hABCD_0000, 1'b1,1'b0},
        // R9 host set and local clear together
        '{4'd9, 1'b1,1'b0,3'd0,32'h0000_0001,  1'b0,1'b1,3'd0,32'h0,          32'h5A5A_0000, 32'h0000_7771, 1'b1,1'b0},
        '{4'd5, 1'b0,1'b0,3'd0,32'h0,          1'b0,1'b1,3'd0,32'h0,          32'h5A5A_0000, 32'h0000_0001, 1'b0,1'b0},
        // R10 unmapped addresses
        '{4'd10,1'b0,1'b1,3'd5,32'h0,          1'b0,1'b0,3'd0,32'h0,          32'h0,         32'h0000_0001, 1'b0,1'b0},
        '{4'd10,1'b0,1'b0,3'd0,32'h0,          1'b0,1'b1,3'd7,32'h0,          32'h0,         32'h0,         1'b0,1'b0},
        // R9 local set and host clear together
        '{4'd9, 1'b0,1'b1,3'd0,32'h0,          1'b1,1'b0,3'd0,32'h0000_0002,  32'h5A5A_0000, 32'h0,         1'b0,1'b1},
        '{4'd7, 1'b0,1'b1,3'd0,32'h0,          1'b0,1'b0,3'd0,32'h0,          32'h0000_0002, 32'h0,         1'b0,1'b0},
        // R10 read in the same cycle as the write returns old data
        '{4'd10,1'b0,1'b1,3'd3,32'h0,          1'b1,1'b0,3'd3,32'h3333_0003,  32'h0,         32'h0,         1'b0,1'b0},
        '{4'd3, 1'b0,1'b1,3'd3,32'h0,          1'b0,1'b0,3'd0,32'h0,          32'h3333_0003, 32'h0,         1'b0,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_irq;
    logic        loc_wr = 1'b0, loc_rd = 1'b0;
    logic [2:0]  loc_addr = '0;
    logic [31:0] loc_wdata = '0;
    logic [31:0] loc_rdata;
    logic        loc_irq;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    mbox_core uut (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .loc_irq(loc_irq)
    );

    task automatic check(input string tag, input vec_t v);
        logic bad;
        bad = 1'b0;
        n_vec++;
        if (host_rdata !== v.eh) begin
            $display("FAIL %s R%0d host_rdata act=%h exp=%h", tag, v.req, host_rdata, v.eh);
            bad = 1'b1;
        end
        if (loc_rdata !== v.el) begin
            $display("FAIL %s R%0d loc_rdata act=%h exp=%h", tag, v.req, loc_rdata, v.el);
            bad = 1'b1;
        end
        if (loc_irq !== v.eli) begin
            $display("FAIL %s R%0d loc_irq act=%b exp=%b", tag, v.req, loc_irq, v.eli);
            bad = 1'b1;
        end
        if (host_irq !== v.ehi) begin
            $display("FAIL %s R%0d host_irq act=%b exp=%b", tag, v.req, host_irq, v.ehi);
            bad = 1'b1;
        end
        if (bad) n_bad++;
    endtask

    // drive on the falling edge, sample half a phase after the rising edge
    task automatic apply(input vec_t v);
        @(negedge clk);
        host_wr = v.hw; host_rd = v.hr; host_addr = v.ha; host_wdata = v.hd;
        loc_wr  = v.lw; loc_rd  = v.lr; loc_addr  = v.la; loc_wdata  = v.ld;
        @(posedge clk);
        #(CLK_P/4);
    endtask

    function automatic vec_t mk(input logic [3:0] req,
                                input logic hw, input logic hr, input logic [2:0] ha, input logic [31:0] hd,
                                input logic lw, input logic lr, input logic [2:0] la, input logic [31:0] ld,
                                input logic [31:0] eh, input logic [31:0] el,
                                input logic eli, input logic ehi);
        return '{req, hw, hr, ha, hd, lw, lr, la, ld, eh, el, eli, ehi};
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        // R1 state while reset is held
        check("reset", mk(4'd1, 0,0,3'd0,32'h0, 0,0,3'd0,32'h0, 32'h0, 32'h0, 1'b0, 1'b0));
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check($sformatf("vec %0d", i), VECS[i]);
        end

        // R1 reset in mid-operation: arm both doorbells and fill data first
        apply(mk(4'd1, 1,0,3'd0,32'hFFFF_FFFF, 1,0,3'd0,32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1, 1'b1));
        apply(mk(4'd1, 1,0,3'd2,32'hDEAD_BEEF, 1,0,3'd4,32'hCAFE_F00D, 32'h0, 32'h0, 1'b1, 1'b1));
        @(negedge clk);
        host_wr = 1'b0; loc_wr = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #(CLK_P/4);
        check("mid reset", mk(4'd1, 0,0,3'd0,32'h0, 0,0,3'd0,32'h0, 32'h0, 32'h0, 1'b0, 1'b0));
        @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 5; a++) begin
            apply(mk(4'd1, 0,1,3'(a),32'h0, 0,1,3'(a),32'h0, 32'h0, 32'h0, 1'b0, 1'b0));
            check($sformatf("post-reset addr %0d", a),
                  mk(4'd1, 0,1,3'(a),32'h0, 0,1,3'(a),32'h0, 32'h0, 32'h0, 1'b0, 1'b0));
        end

        // R5 single-step clear: flag set, idle cycle keeps it, read drops it
        apply(mk(4'd4, 1,0,3'd0,32'h0000_0001, 0,0,3'd0,32'h0, 32'h0, 32'h0, 1'b1, 1'b0));
        check("r4 set", mk(4'd4, 0,0,3'd0,32'h0, 0,0,3'd0,32'h0, 32'h0, 32'h0, 1'b1, 1'b0));
        apply(mk(4'd8, 0,0,3'd0,32'h0, 0,0,3'd0,32'h0, 32'h0, 32'h0, 1'b1, 1'b0));
        check("r8 idle hold", mk(4'd8, 0,0,3'd0,32'h0, 0,0,3'd0,32'h0, 32'h0, 32'h0, 1'b1, 1'b0));
        apply(mk(4'd5, 0,0,3'd0,32'h0, 0,1,3'd0,32'h0, 32'h0, 32'h1, 1'b0, 1'b0));
        check("r5 clear", mk(4'd5, 0,0,3'd0,32'h0, 0,1,3'd0,32'h0, 32'h0, 32'h1, 1'b0, 1'b0));

        @(negedge clk);
        loc_rd = 1'b0;
        finish_run();
    end

endmodule